// File: doc/BRIEF.md
# Supply-Loss Write Guard

This block sits between two supply comparators and a bank of clock and storage registers. One comparator flag reports that the main supply has dropped under a warning level. The block reacts by locking out register writes. The other flag reports a deeper drop under a lower level, and the block then selects a backup cell as the power source. Both flags are asynchronous to the register clock, so the block resynchronises them before it uses them.

When the warning flag clears, the write lock is not dropped at once. A hold-off counter has to count a programmable number of good-supply cycles first. If the supply dips again during that window, the count starts over. Reset is treated like a power-up: the lock is held for a full hold-off window before the first write is allowed. A complementary write-enable output drives the register file's write gating directly. The block never resets anything downstream: a switch to the backup source changes only the source-select output, so timekeeping and stored data carry on.

Top module: `pfws_top`

## Requirements
- R1: While `rst_n` is low, `wr_lock_o` is 1, `wr_ok_o` is 0 and `on_backup_o` is 0.
- R2: After `rst_n` rises with both supply flags low and `hold_len_i` = L (L ≥ 1), `wr_lock_o` stays 1 through the first L-1 rising clock edges. It reads 0 after the L-th edge.
- R3: A 1 on `supply_warn_i` sets `wr_lock_o` after the second rising edge that samples it. After the first such edge, `wr_lock_o` is still unchanged.
- R4: Once `supply_warn_i` returns to 0 and stays there, `wr_lock_o` stays 1 through the first L+2 rising edges. It reads 0 after edge L+3. The write window then stays open while no flag is set.
- R5: Any new 1 on a supply flag during the hold-off window restarts the window. R4's timing then counts from the moment the flag falls again.
- R6: A 1 on `supply_crit_i` sets `on_backup_o` after the third rising edge. It also sets `wr_lock_o` after the second rising edge, even when `supply_warn_i` is 0.
- R7: When `supply_crit_i` returns to 0, `on_backup_o` returns to 0 after the third rising edge. The main supply is then selected again.
- R8: `wr_ok_o` is always the inverse of `wr_lock_o`.
- R9: Whenever `on_backup_o` is 1, `wr_lock_o` is also 1.
- R10: A `hold_len_i` of 0 gives the same timing as a value of 1.
- R11: `hold_len_i` is read as a count of clock cycles and must stay stable while writes are locked. Within the window, the hold-off count never reaches `hold_len_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low reset, treated as power-up |
| supply_warn_i | input | 1 | Asynchronous flag: supply under the write-lock level |
| supply_crit_i | input | 1 | Asynchronous flag: supply under the backup-switch level |
| hold_len_i | input | HOLD_W | Hold-off length in clock cycles |
| wr_lock_o | output | 1 | 1 = writes to clock and storage registers blocked |
| wr_ok_o | output | 1 | Inverse of wr_lock_o, for the register-file write enable |
| on_backup_o | output | 1 | 1 = backup cell selected as power source |

## Verification
The assertions watch the hold-off state machine on every cycle. They check that any failure flag returns it to the locked state with a zeroed count. They check that the write window can only open from a completed hold-off with no pending failure, that an open window stays open while the supply is good, and that the count stays under the programmed length. They also check that backup selection never coincides with open writes. Only the bench scenarios can show the exact cycle latencies: flag to lock, flag to source switch, and recovery to release. The same holds for the reset-time hold-off, the restart after a short dip, and the equal treatment of lengths 0 and 1.

// File: rtl/pfws_pkg.sv
package pfws_pkg;

    typedef enum logic [1:0] {
        ST_LOCK = 2'd0,
        ST_HOLD = 2'd1,
        ST_OPEN = 2'd2
    } guard_st_e;

endpackage

// File: rtl/pfws_sync.sv
module pfws_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    localparam int LAST = STAGES - 1;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_d;
        logic [STAGES-1:0] chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_i[b]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '0;
            end else begin
                chain_q <= chain_d;
            end
        end

        assign sync_o[b] = chain_q[LAST];
    end

endmodule

// File: rtl/pfws_holdoff.sv
module pfws_holdoff
    import pfws_pkg::*;
#(
    parameter int HOLD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fail_i,
    input  logic [HOLD_W-1:0] hold_len_i,
    output logic              locked_o
);

    typedef struct packed {
        guard_st_e         st;
        logic [HOLD_W-1:0] cnt;
    } hold_t;

    hold_t r_d;
    hold_t r_q;
    logic  cnt_done;

    // A zero length is treated as one cycle of hold-off.
    assign cnt_done = (hold_len_i == '0) || (r_q.cnt >= hold_len_i - HOLD_W'(1));

    always_comb begin
        r_d = r_q;
        if (fail_i) begin
            r_d.st  = ST_LOCK;
            r_d.cnt = '0;
        end else begin
            unique case (r_q.st)
                ST_LOCK: begin
                    r_d.st  = ST_HOLD;
                    r_d.cnt = '0;
                end
                ST_HOLD: begin
                    if (cnt_done) begin
                        r_d.st  = ST_OPEN;
                        r_d.cnt = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + HOLD_W'(1);
                    end
                end
                ST_OPEN: begin
                    r_d.st = ST_OPEN;
                end
                default: begin
                    r_d.st  = ST_LOCK;
                    r_d.cnt = '0;
                end
            endcase
        end
    end

    // Reset behaves as a power-up: start a full hold-off window.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= ST_HOLD;
            r_q.cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign locked_o = (r_q.st != ST_OPEN);

    AST_FAIL_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        fail_i |=> (r_q.st == ST_LOCK && r_q.cnt == '0)); // R5

    AST_OPEN_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.st == ST_OPEN) |-> ($past(r_q.st) == ST_HOLD && !$past(fail_i))); // R4

    AST_OPEN_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_OPEN && !fail_i) |=> (r_q.st == ST_OPEN)); // R4

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_HOLD && hold_len_i != '0) |-> (r_q.cnt < hold_len_i)); // R11

endmodule

// File: rtl/pfws_src_sel.sv
module pfws_src_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic crit_i,
    output logic on_backup_o
);

    logic bk_d;
    logic bk_q;

    always_comb begin
        bk_d = crit_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bk_q <= 1'b0;
        end else begin
            bk_q <= bk_d;
        end
    end

    assign on_backup_o = bk_q;

endmodule

// File: rtl/pfws_top.sv
module pfws_top #(
    parameter int HOLD_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_warn_i,
    input  logic              supply_crit_i,
    input  logic [HOLD_W-1:0] hold_len_i,
    output logic              wr_lock_o,
    output logic              wr_ok_o,
    output logic              on_backup_o
);

    localparam int FLAG_N = 2;

    logic [FLAG_N-1:0] flags_s;
    logic              warn_s;
    logic              crit_s;
    logic              fail_s;
    logic              held;

    pfws_sync #(
        .WIDTH  (FLAG_N),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({supply_crit_i, supply_warn_i}),
        .sync_o  (flags_s)
    );

    assign warn_s = flags_s[0];
    assign crit_s = flags_s[1];
    // A drop under the lower level also counts as a power failure.
    assign fail_s = warn_s | crit_s;

    pfws_holdoff #(
        .HOLD_W (HOLD_W)
    ) u_holdoff (
        .clk        (clk),
        .rst_n      (rst_n),
        .fail_i     (fail_s),
        .hold_len_i (hold_len_i),
        .locked_o   (held)
    );

    pfws_src_sel u_src (
        .clk         (clk),
        .rst_n       (rst_n),
        .crit_i      (crit_s),
        .on_backup_o (on_backup_o)
    );

    // Lock combinationally from the synchronised flag to save a cycle.
    assign wr_lock_o = ~rst_n | fail_s | held;
    assign wr_ok_o   = ~wr_lock_o;

    AST_BACKUP_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        on_backup_o |-> wr_lock_o); // R9

    AST_FAIL_LOCKS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        fail_s |=> wr_lock_o); // R3

endmodule

// File: tb/pfws_top_tb.sv
`timescale 1ns/1ps
module pfws_top_tb;

    localparam int HW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          warn = 1'b0;
    logic          crit = 1'b0;
    logic [HW-1:0] hlen = 16'd5;
    logic          wr_lock;
    logic          wr_ok;
    logic          on_bk;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pfws_top #(.HOLD_W(HW), .SYNC_STAGES(2)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .supply_warn_i (warn),
        .supply_crit_i (crit),
        .hold_len_i    (hlen),
        .wr_lock_o     (wr_lock),
        .wr_ok_o       (wr_ok),
        .on_backup_o   (on_bk)
    );

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Checks lock and backup, and the R8 inverse relation every time.
    task automatic chk_outs(input string tag, input logic lk, input logic bk);
        chk({tag, " lock"}, wr_lock, lk);
        chk({tag, " backup"}, on_bk, bk);
        chk("R8 wr_ok inverse", wr_ok, ~wr_lock);
    endtask

    task automatic t_reset(input int len);
        rst_n = 1'b0;
        warn = 1'b0;
        crit = 1'b0;
        hlen = HW'(len);
        tick(3);
        chk_outs("R1 in reset", 1'b1, 1'b0);
        rst_n = 1'b1;
        tick(len - 1);
        chk_outs("R2 before window end", 1'b1, 1'b0);
        tick(1);
        chk_outs("R2 after window end", 1'b0, 1'b0);
    endtask

    task automatic t_warn(input int len);
        warn = 1'b1;
        tick(1);
        chk_outs("R3 one edge", 1'b0, 1'b0);
        tick(1);
        chk_outs("R3 two edges", 1'b1, 1'b0);
        tick(3);
        warn = 1'b0;
        tick(len + 2);
        chk_outs("R4 still held", 1'b1, 1'b0);
        tick(1);
        chk_outs("R4 released", 1'b0, 1'b0);
        tick(6);
        chk_outs("R4 stays open", 1'b0, 1'b0);
    endtask

    task automatic t_dip(input int len);
        warn = 1'b1;
        tick(4);
        warn = 1'b0;
        tick(3);
        warn = 1'b1;
        tick(1);
        warn = 1'b0;
        tick(len + 2);
        chk_outs("R5 restarted window held", 1'b1, 1'b0);
        tick(1);
        chk_outs("R5 restarted window released", 1'b0, 1'b0);
    endtask

    task automatic t_backup(input int len);
        crit = 1'b1;
        tick(2);
        chk_outs("R6 lock from crit alone", 1'b1, 1'b0);
        tick(1);
        chk_outs("R6 backup selected", 1'b1, 1'b1);
        tick(4);
        crit = 1'b0;
        tick(2);
        chk_outs("R7 backup still on", 1'b1, 1'b1);
        tick(1);
        chk_outs("R7 main selected, R9 lock kept", 1'b1, 1'b0);
        tick(len - 1);
        chk_outs("R4 after backup held", 1'b1, 1'b0);
        tick(1);
        chk_outs("R4 after backup released", 1'b0, 1'b0);
    endtask

    task automatic t_zero_len();
        hlen = '0;
        warn = 1'b1;
        tick(2);
        warn = 1'b0;
        tick(3);
        chk_outs("R10 zero length held", 1'b1, 1'b0);
        tick(1);
        chk_outs("R10 zero length released", 1'b0, 1'b0);
    endtask

    initial begin
        tick(1);
        t_reset(5);
        t_warn(5);
        t_dip(5);
        t_backup(5);
        hlen = 16'd9;
        t_warn(9);
        t_zero_len();
        hlen = 16'd1;
        t_dip(1);
        t_reset(12);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule